// File: doc/BRIEF.md
# PHY Crossover and Link Resolution Sequencer

This block brings one Ethernet PHY port from power-up to a known link state without software. After a start pulse it issues a chain of single register reads to the PHY over a simple request/response port, then checks for line energy. It then waits for link, flipping the crossover-select output after every failed link attempt, and finally resolves speed, duplex and flow-control pause into a small packed status word.

The read port is transport-neutral. A one-cycle request carries a PHY address and a register number, and the responder returns one data word with an acknowledge. Whatever serial management engine sits behind it is outside this block. A free-running tick paces the link retries so that the physical layer has time to train between attempts. When the sequence ends, `done_o` pulses for one cycle. `nolink_o` pulses with it when no link could be found.

Top module: `xover_link_seq`

## Requirements
- R1: While `rst_ni` is low, `stat_o`, `xover_o`, `rd_req_o`, `done_o` and `nolink_o` are all 0.
- R2: Each read request is a one-cycle `rd_req_o` pulse with `rd_phy_o` equal to `PHY_ADDR` (default 6). No new request is issued until the previous one has been answered by `rd_ack_i`.
- R3: A `start_i` pulse while idle clears `stat_o` and `xover_o` and starts the sequence with a read of register 17. A `start_i` pulse while a sequence runs has no effect on the reads issued or the results.
- R4: Energy detection tests bit 1 of register 17. On a clear bit the read is repeated at once, for at most `SIG_TRIES` reads in total. After that the sequence ends with no link.
- R5: Link detection reads register 1 and tests bit 2. Every register 1 request is issued in the cycle after `tick_i` was sampled high. Each read that shows no link inverts `xover_o`. After `LINK_TRIES` failed reads the sequence ends with no link.
- R6: On a no-link outcome, `done_o` and `nolink_o` pulse together for one cycle, `stat_o` stays 0, and the block returns to idle.
- R7: When a link is found, `done_o` pulses without `nolink_o` and status bit 0 (link) is set. If bit 5 of that same register 1 response is clear, no further reads are made and the other status bits are 0.
- R8: If register 1 bit 5 is set, register 31 is read and its bits 4:2 are decoded. Code 1 gives 10 Mb/s half duplex, 5 gives 10 Mb/s full, 2 gives 100 Mb/s half and 6 gives 100 Mb/s full. Status bit 2 marks 100 Mb/s and bit 1 marks full duplex. Any other code leaves both bits 0.
- R9: Pause is resolved only when register 1 bits 5 and 3 are both set. The block then reads register 6 (bit 0), then 4 (bit 10), then 5 (bit 10), stopping at the first clear bit. Status bit 3 is set only if all three bits are set.
- R10: `stat_o` changes only at `done_o` or on the cycle after an accepted start, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a bring-up sequence when idle |
| tick_i | input | 1 | Retry pacing strobe for link attempts |
| rd_req_o | output | 1 | One-cycle register read request |
| rd_phy_o | output | ADDR_W | PHY address of the request |
| rd_reg_o | output | ADDR_W | Register number of the request |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | DATA_W | Read response data |
| xover_o | output | 1 | Crossover select |
| done_o | output | 1 | Sequence finished, one-cycle pulse |
| nolink_o | output | 1 | Finished without link, pulses with done_o |
| stat_o | output | 4 | Bit 0 link, bit 1 full duplex, bit 2 100 Mb/s, bit 3 pause |

## Verification
The bench builds the block with `SIG_TRIES` = 3 and `LINK_TRIES` = 4 instead of 100. This brings both retry exhaustion paths, and the even and odd number of crossover flips before a link, within a few hundred cycles. A stub PHY answers every read two cycles after the request. It plants noise in unrelated bits and scripts how many energy and link attempts fail, so the register order, the early exits of the pause chain and the unknown speed code can each be steered directly.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP, ST_TICK} st_e;
  typedef enum logic [2:0] {Q_SIG, Q_LINK, Q_SPD, Q_ANX, Q_ADV, Q_LPA} qry_e;

  localparam int STAT_W  = 4;
  localparam int S_LINK  = 0;
  localparam int S_FULL  = 1;
  localparam int S_FAST  = 2;
  localparam int S_PAUSE = 3;

  localparam logic [4:0] REG_BSR = 5'd1;
  localparam logic [4:0] REG_ADV = 5'd4;
  localparam logic [4:0] REG_LPA = 5'd5;
  localparam logic [4:0] REG_ANX = 5'd6;
  localparam logic [4:0] REG_MCS = 5'd17;
  localparam logic [4:0] REG_SCS = 5'd31;

  localparam int B_SIG    = 1;
  localparam int B_LINK   = 2;
  localparam int B_ANABLE = 3;
  localparam int B_ANDONE = 5;
  localparam int B_LPAN   = 0;
  localparam int B_PAUSE  = 10;
  localparam int SPD_LSB  = 2;
  localparam int SPD_W    = 3;
endpackage

// File: rtl/lsq_try_cnt.sv
module lsq_try_cnt #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == lim_i);
endmodule

// File: rtl/lsq_spd_decode.sv
module lsq_spd_decode #(
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              fast_o,
  output logic              full_o
);
  always_comb begin
    fast_o = 1'b0;
    full_o = 1'b0;
    case (code_i)
      CODE_W'(1): ;
      CODE_W'(5): full_o = 1'b1;
      CODE_W'(2): fast_o = 1'b1;
      CODE_W'(6): begin fast_o = 1'b1; full_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/xover_link_seq.sv
module xover_link_seq
  import lsq_pkg::*;
#(
  parameter int PHY_ADDR   = 6,
  parameter int SIG_TRIES  = 100,
  parameter int LINK_TRIES = 100,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_phy_o,
  output logic [ADDR_W-1:0] rd_reg_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              xover_o,
  output logic              done_o,
  output logic              nolink_o,
  output logic [STAT_W-1:0] stat_o
);
  localparam int MAX_TRIES = (SIG_TRIES > LINK_TRIES) ? SIG_TRIES : LINK_TRIES;
  localparam int CNT_W     = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

  st_e  st_q, st_d;
  qry_e qry_q, qry_d;
  logic [STAT_W-1:0] acc_q, acc_d;
  logic an_q, an_d;
  logic fin, fail, tog, cnt_clr, cnt_inc, cnt_last;
  logic spd_fast, spd_full;
  logic [CNT_W-1:0] lim;
  logic data_unused;

  assign data_unused = ^rd_data_i;
  assign lim = (qry_q == Q_SIG) ? CNT_W'(SIG_TRIES - 1) : CNT_W'(LINK_TRIES - 1);

  lsq_try_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .lim_i  (lim),
    .last_o (cnt_last)
  );

  lsq_spd_decode #(.CODE_W(SPD_W)) u_spd (
    .code_i (rd_data_i[SPD_LSB +: SPD_W]),
    .fast_o (spd_fast),
    .full_o (spd_full)
  );

  always_comb begin
    case (qry_q)
      Q_SIG:   rd_reg_o = ADDR_W'(REG_MCS);
      Q_LINK:  rd_reg_o = ADDR_W'(REG_BSR);
      Q_SPD:   rd_reg_o = ADDR_W'(REG_SCS);
      Q_ANX:   rd_reg_o = ADDR_W'(REG_ANX);
      Q_ADV:   rd_reg_o = ADDR_W'(REG_ADV);
      Q_LPA:   rd_reg_o = ADDR_W'(REG_LPA);
      default: rd_reg_o = '0;
    endcase
  end

  assign rd_req_o = (st_q == ST_REQ);
  assign rd_phy_o = ADDR_W'(PHY_ADDR);

  always_comb begin
    st_d    = st_q;
    qry_d   = qry_q;
    acc_d   = acc_q;
    an_d    = an_q;
    fin     = 1'b0;
    fail    = 1'b0;
    tog     = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d    = ST_REQ;
        qry_d   = Q_SIG;
        acc_d   = '0;
        cnt_clr = 1'b1;
      end
      ST_REQ:  st_d = ST_RSP;
      ST_TICK: if (tick_i) st_d = ST_REQ;
      ST_RSP: if (rd_ack_i) begin
        case (qry_q)
          Q_SIG:
            if (rd_data_i[B_SIG]) begin
              qry_d = Q_LINK; cnt_clr = 1'b1; st_d = ST_TICK;
            end else if (cnt_last) fail = 1'b1;
            else begin cnt_inc = 1'b1; st_d = ST_REQ; end
          Q_LINK:
            if (rd_data_i[B_LINK]) begin
              acc_d[S_LINK] = 1'b1;
              an_d = rd_data_i[B_ANABLE];
              if (rd_data_i[B_ANDONE]) begin qry_d = Q_SPD; st_d = ST_REQ; end
              else fin = 1'b1;
            end else begin
              tog = 1'b1;
              if (cnt_last) fail = 1'b1;
              else begin cnt_inc = 1'b1; st_d = ST_TICK; end
            end
          Q_SPD: begin
            acc_d[S_FAST] = spd_fast;
            acc_d[S_FULL] = spd_full;
            if (an_q) begin qry_d = Q_ANX; st_d = ST_REQ; end
            else fin = 1'b1;
          end
          Q_ANX:
            if (rd_data_i[B_LPAN]) begin qry_d = Q_ADV; st_d = ST_REQ; end
            else fin = 1'b1;
          Q_ADV:
            if (rd_data_i[B_PAUSE]) begin qry_d = Q_LPA; st_d = ST_REQ; end
            else fin = 1'b1;
          Q_LPA: begin
            acc_d[S_PAUSE] = rd_data_i[B_PAUSE];
            fin = 1'b1;
          end
          default: fail = 1'b1;
        endcase
        if (fin || fail) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      qry_q    <= Q_SIG;
      acc_q    <= '0;
      an_q     <= 1'b0;
      stat_o   <= '0;
      xover_o  <= 1'b0;
      done_o   <= 1'b0;
      nolink_o <= 1'b0;
    end else begin
      st_q     <= st_d;
      qry_q    <= qry_d;
      acc_q    <= acc_d;
      an_q     <= an_d;
      done_o   <= fin | fail;
      nolink_o <= fail;
      if (st_q == ST_IDLE && start_i) begin
        stat_o  <= '0;
        xover_o <= 1'b0;
      end else begin
        if (fin) stat_o <= acc_d;
        if (tog) xover_o <= ~xover_o;
      end
    end
  end
endmodule

// File: rtl/xover_link_seq_chk.sv
module xover_link_seq_chk
  import lsq_pkg::*;
#(
  parameter int PHY_ADDR = 6,
  parameter int ADDR_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              tick_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_phy_o,
  input logic [ADDR_W-1:0] rd_reg_o,
  input logic              rd_ack_i,
  input logic              xover_o,
  input logic              done_o,
  input logic              nolink_o,
  input logic [STAT_W-1:0] stat_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (rd_req_o) pend_q <= 1'b1;
    else if (rd_ack_i) pend_q <= 1'b0;
  end

  // R2
  phy_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_phy_o == ADDR_W'(PHY_ADDR));

  // R2
  single_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !pend_q);

  // R5
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_reg_o == ADDR_W'(REG_BSR)) |-> $past(tick_i));

  // R5
  xover_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(xover_o) |-> ($past(rd_ack_i) || $past(start_i)));

  // R6
  nolink_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nolink_o |-> (done_o && stat_o == '0));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  link_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !nolink_o) |-> stat_o[S_LINK]);

  // R10
  stat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stat_o) |-> (done_o || $past(start_i)));
endmodule

bind xover_link_seq xover_link_seq_chk #(
  .PHY_ADDR (PHY_ADDR),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .tick_i   (tick_i),
  .rd_req_o (rd_req_o),
  .rd_phy_o (rd_phy_o),
  .rd_reg_o (rd_reg_o),
  .rd_ack_i (rd_ack_i),
  .xover_o  (xover_o),
  .done_o   (done_o),
  .nolink_o (nolink_o),
  .stat_o   (stat_o)
);

// File: tb/xover_link_seq_tb_top.sv
`timescale 1ns/1ps
module xover_link_seq_tb_top;
  localparam int SIG_T  = 3;
  localparam int LINK_T = 4;
  localparam int PHY    = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick = 1'b0, ack = 1'b0;
  logic [15:0] rdat = '0;
  logic rd_req, xover, done, nolink;
  logic [4:0] rd_phy, rd_reg;
  logic [3:0] stat;

  always #2.5 clk = ~clk;

  xover_link_seq #(
    .PHY_ADDR(PHY), .SIG_TRIES(SIG_T), .LINK_TRIES(LINK_T), .ADDR_W(5), .DATA_W(16)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tick_i(tick),
    .rd_req_o(rd_req), .rd_phy_o(rd_phy), .rd_reg_o(rd_reg),
    .rd_ack_i(ack), .rd_data_i(rdat),
    .xover_o(xover), .done_o(done), .nolink_o(nolink), .stat_o(stat)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scenario and reference model state
  int sig_f, link_f, code, sig_n, link_n, lat, cur_reg, extra_at, run_cyc, cyc;
  logic [15:0] r1b, r6v, r4v, r5v;
  int exp_q[$];
  logic [3:0] pred_stat, exp_stat;
  bit pred_nolink, pred_x, exp_x;
  bit clr_pend, tog_pend, busy_rd, running, launch, finished, active;

  initial begin
    exp_stat = '0; exp_x = 0; clr_pend = 0; tog_pend = 0; busy_rd = 0;
    running = 0; launch = 0; finished = 0; active = 0; cyc = 0; lat = 0;
  end

  always @(negedge clk) if (active) begin
    cyc++;
    if (clr_pend) begin exp_stat = '0; exp_x = 0; clr_pend = 0; end
    if (tog_pend) begin exp_x = !exp_x; tog_pend = 0; end
    if (done) begin
      chk(exp_q.size() == 0, "R3", "reads left at done", exp_q.size(), 0);
      chk(nolink == pred_nolink, "R6", "nolink at done", nolink, pred_nolink);
      chk(stat[0] == !pred_nolink, "R7", "link bit", stat[0], !pred_nolink);
      chk(stat[2:1] == pred_stat[2:1], "R8", "speed/duplex", stat[2:1], pred_stat[2:1]);
      chk(stat[3] == pred_stat[3], "R9", "pause", stat[3], pred_stat[3]);
      chk(xover == pred_x, "R5", "final crossover", xover, pred_x);
      exp_stat = pred_stat;
      finished = 1; running = 0;
    end else if (nolink) chk(0, "R6", "nolink without done", nolink, 0);
    chk(stat == exp_stat, "R10", "status", stat, exp_stat);
    chk(xover == exp_x, "R5", "crossover", xover, exp_x);
    if (rd_req) begin
      chk(!busy_rd, "R2", "overlapping read", 1, 0);
      chk(rd_phy == PHY, "R2", "phy address", rd_phy, PHY);
      if (exp_q.size() == 0) chk(0, "R3", "unexpected read", rd_reg, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(rd_reg == e, "R4", "read register", rd_reg, e);
      end
      if (rd_reg == 1) chk(tick, "R5", "link read without tick", tick, 1);
      busy_rd = 1; lat = 2; cur_reg = rd_reg;
    end
    // drive
    start = 0; ack = 0;
    if (busy_rd && !rd_req) begin
      lat--;
      if (lat == 0) begin
        ack = 1; busy_rd = 0;
        case (cur_reg)
          17: begin rdat = (sig_n < sig_f) ? 16'hFFFD : 16'h0002; sig_n++; end
          1: begin
            if (link_n < link_f) begin rdat = r1b & ~16'h0004; tog_pend = 1; end
            else rdat = r1b | 16'h0004;
            link_n++;
          end
          31: rdat = {8'hA5, 3'b111, 3'(code), 2'b11};
          6: rdat = r6v;
          4: rdat = r4v;
          5: rdat = r5v;
          default: rdat = 16'h0;
        endcase
      end
    end else if (busy_rd) lat--;
    tick = (cyc % 4 == 0);
    if (launch) begin start = 1; launch = 0; clr_pend = 1; running = 1; run_cyc = 0; end
    else if (running) begin run_cyc++; if (run_cyc == extra_at) start = 1; end
  end

  task automatic scen(input int sf, input int lf, input logic [15:0] r1, input int cd,
                      input logic [15:0] a6, input logic [15:0] a4, input logic [15:0] a5,
                      input int extra);
    sig_f = sf; link_f = lf; r1b = r1; code = cd; r6v = a6; r4v = a4; r5v = a5;
    extra_at = extra; sig_n = 0; link_n = 0;
    exp_q.delete(); pred_stat = '0; pred_nolink = 0; pred_x = 0;
    for (int i = 0; i < SIG_T && i < sf; i++) exp_q.push_back(17);
    if (sf >= SIG_T) pred_nolink = 1;
    else begin
      exp_q.push_back(17);
      for (int i = 0; i < LINK_T && i < lf; i++) begin exp_q.push_back(1); pred_x = !pred_x; end
      if (lf >= LINK_T) pred_nolink = 1;
      else begin
        exp_q.push_back(1);
        pred_stat[0] = 1;
        if (r1[5]) begin
          exp_q.push_back(31);
          case (cd)
            5: pred_stat[1] = 1;
            2: pred_stat[2] = 1;
            6: pred_stat[2:1] = 2'b11;
            default: ;
          endcase
          if (r1[3]) begin
            exp_q.push_back(6);
            if (a6[0]) begin
              exp_q.push_back(4);
              if (a4[10]) begin
                exp_q.push_back(5);
                if (a5[10]) pred_stat[3] = 1;
              end
            end
          end
        end
      end
    end
    finished = 0; launch = 1;
    wait (finished);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(stat == 0, "R1", "reset status", stat, 0);
    chk(xover == 0, "R1", "reset crossover", xover, 0);
    chk(!rd_req && !done && !nolink, "R1", "reset strobes", {rd_req, done, nolink}, 0);
    rst_n = 1;
    @(negedge clk);
    active = 1;
    repeat (2) @(negedge clk);
    scen(0, 0, 16'h0028, 6, 16'h0001, 16'h0400, 16'h0400, 0);   // full resolution, stat F
    scen(2, 3, 16'h0020, 1, 16'h0001, 16'h0400, 16'h0400, 0);   // retries, no autoneg
    scen(3, 0, 16'h0028, 6, 16'h0001, 16'h0400, 16'h0400, 0);   // R4 energy exhausted
    scen(0, 4, 16'h0028, 6, 16'h0001, 16'h0400, 16'h0400, 0);   // R5 link exhausted
    scen(1, 1, 16'h0008, 6, 16'h0001, 16'h0400, 16'h0400, 0);   // R7 no speed lookup
    scen(0, 2, 16'h0028, 5, 16'h0000, 16'h0400, 16'h0400, 0);   // R9 partner no autoneg
    scen(0, 0, 16'h0028, 2, 16'h0001, 16'hFBFF, 16'h0400, 0);   // R9 no local pause
    scen(0, 1, 16'h0028, 7, 16'h0001, 16'h0400, 16'h0400, 0);   // R8 unknown code
    scen(0, 0, 16'h0028, 0, 16'h0001, 16'h0400, 16'h0400, 0);   // R8 code zero
    scen(0, 0, 16'h0028, 6, 16'h0001, 16'h0400, 16'hFBFF, 0);   // R9 no partner pause
    scen(1, 2, 16'h0028, 6, 16'h0001, 16'h0400, 16'h0400, 9);   // R3 start while busy
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule